// File: doc/BRIEF.md
# Split Six-Position Up/Down Counter

This block counts through six positions, 0 to 5, under two command inputs: one steps the count upward, the other steps it downward, and both directions wrap around. It does not use a single three-bit state register. Instead, two small sequencers each own three adjacent positions plus one parking state. The lower sequencer covers positions 0 to 2. The upper sequencer covers positions 3 to 5. Each sequencer uses a two-bit register.

At any moment one sequencer is counting and the other is parked. When the count crosses from one half to the other, the active sequencer parks itself. In the same clock edge, the parked sequencer sees that its peer sits at the matching edge position and moves to its entry position. Each sequencer looks only at the two commands and at its peer's state.

The count output is decoded from whichever sequencer is not parked. Both sequencer states are also brought out, so the handover can be observed.

Top module: `split_updown_counter`

## Requirements
- R1: While reset is asserted (rst_n low), and after its release with no command, count is 0, lo_state is 2'b00 and hi_state is 2'b11. Sequencer state codes are 2'b00, 2'b01 and 2'b10 for the first, second and third position of a half, and 2'b11 for parked.
- R2: With up high and dn low at a rising clock edge, count after that edge is the previous count plus one, and 5 wraps to 0.
- R3: With dn high and up low at a rising clock edge, count after that edge is the previous count minus one, and 0 wraps to 5.
- R4: With up and dn both low, or both high, at a rising clock edge, count, lo_state and hi_state keep their values across that edge.
- R5: Outside reset, exactly one of lo_state and hi_state equals 2'b11 (parked).
- R6: An up step from count 2 leaves lo_state at 2'b11 and hi_state at 2'b00.
- R7: An up step from count 5 leaves hi_state at 2'b11 and lo_state at 2'b00.
- R8: A down step from count 3 leaves hi_state at 2'b11 and lo_state at 2'b10.
- R9: A down step from count 0 leaves lo_state at 2'b11 and hi_state at 2'b10.
- R10: When hi_state is parked, count equals lo_state. When lo_state is parked, count equals 3 plus hi_state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up | input | 1 | Step the count upward |
| dn | input | 1 | Step the count downward |
| count | output | COUNT_W | Decoded position, 0 to 5 |
| lo_state | output | 2 | State of the lower sequencer (positions 0 to 2) |
| hi_state | output | 2 | State of the upper sequencer (positions 3 to 5) |

## Verification
The command presented at a rising edge is registered in both sequencers at that same edge. The count is then decoded combinationally from the registered states, so every result (count and both states) is due one edge after its command, including a handover between halves. The bench changes the commands on the falling edge. It checks the registered results one time unit after the next rising edge and compares them with a position model kept in the bench. The boundary tasks check both sequencer states right after each crossing. The hold tasks check that nothing moved after the idle and conflicting command combinations.

// File: rtl/split_counter_pkg.sv
package split_counter_pkg;
   localparam int unsigned HALF_W    = 2;
   localparam int unsigned HALF_SPAN = 3;

   typedef enum logic [HALF_W-1:0] {
      POS_FIRST  = 2'b00,
      POS_MID    = 2'b01,
      POS_LAST   = 2'b10,
      POS_PARKED = 2'b11
   } half_st_t;
endpackage

// File: rtl/half_sequencer.sv
module half_sequencer
   import split_counter_pkg::*;
#(
   parameter bit START_PARKED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_up,
   input  logic              step_dn,
   input  logic [HALF_W-1:0] peer_st,
   output logic [HALF_W-1:0] st
);
   localparam logic [HALF_W-1:0] RESET_CODE = START_PARKED ? POS_PARKED : POS_FIRST;

   half_st_t cur_q, nxt;
   half_st_t peer;

   assign peer = half_st_t'(peer_st);

   always_comb begin
      nxt = cur_q;
      unique case (cur_q)
         POS_FIRST: begin
            if (step_up)      nxt = POS_MID;
            else if (step_dn) nxt = POS_PARKED;
         end
         POS_MID: begin
            if (step_up)      nxt = POS_LAST;
            else if (step_dn) nxt = POS_FIRST;
         end
         POS_LAST: begin
            if (step_up)      nxt = POS_PARKED;
            else if (step_dn) nxt = POS_MID;
         end
         POS_PARKED: begin
            if (step_up && peer == POS_LAST)       nxt = POS_FIRST;
            else if (step_dn && peer == POS_FIRST) nxt = POS_LAST;
         end
         default: nxt = cur_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= half_st_t'(RESET_CODE);
      else        cur_q <= nxt;
   end

   assign st = cur_q;
endmodule

// File: rtl/position_decode.sv
module position_decode
   import split_counter_pkg::*;
#(
   parameter int unsigned COUNT_W = 3
) (
   input  logic [HALF_W-1:0]  lo_st,
   input  logic [HALF_W-1:0]  hi_st,
   output logic [COUNT_W-1:0] pos
);
   localparam logic [COUNT_W-1:0] HI_BASE = COUNT_W'(HALF_SPAN);

   always_comb begin
      if (lo_st == POS_PARKED) pos = HI_BASE + COUNT_W'(hi_st);
      else                     pos = COUNT_W'(lo_st);
   end
endmodule

// File: rtl/split_updown_counter.sv
module split_updown_counter
   import split_counter_pkg::*;
#(
   parameter int unsigned COUNT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               up,
   input  logic               dn,
   output logic [COUNT_W-1:0] count,
   output logic [1:0]         lo_state,
   output logic [1:0]         hi_state
);
   localparam int unsigned TOTAL_POS = 2 * HALF_SPAN;

   generate
      if ((1 << COUNT_W) < TOTAL_POS) begin : g_bad_width
         $error("COUNT_W too narrow for six positions");
      end
   endgenerate

   logic step_up, step_dn;
   logic [HALF_W-1:0] lo_st, hi_st;

   assign step_up = up & ~dn;
   assign step_dn = dn & ~up;

   half_sequencer #(.START_PARKED(1'b0)) u_lo (
      .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
      .peer_st(hi_st), .st(lo_st)
   );

   half_sequencer #(.START_PARKED(1'b1)) u_hi (
      .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
      .peer_st(lo_st), .st(hi_st)
   );

   position_decode #(.COUNT_W(COUNT_W)) u_dec (
      .lo_st(lo_st), .hi_st(hi_st), .pos(count)
   );

   assign lo_state = lo_st;
   assign hi_state = hi_st;
endmodule

// File: rtl/split_counter_chk.sv
module split_counter_chk #(
   parameter int unsigned COUNT_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               up,
   input logic               dn,
   input logic [COUNT_W-1:0] count,
   input logic [1:0]         lo_state,
   input logic [1:0]         hi_state
);
   localparam logic [COUNT_W-1:0] TOP = COUNT_W'(5);
   localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

   // R2
   up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !dn) |=> count == (($past(count) == TOP) ? '0 : $past(count) + ONE));

   // R3
   dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && !up) |=> count == (($past(count) == '0) ? TOP : $past(count) - ONE));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up == dn) |=> ($stable(count) && $stable(lo_state) && $stable(hi_state)));

   // R5
   one_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lo_state == 2'b11) != (hi_state == 2'b11)));

   // R6
   up_into_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !dn && count == COUNT_W'(2)) |=> (lo_state == 2'b11 && hi_state == 2'b00));

   // R7
   up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !dn && count == TOP) |=> (hi_state == 2'b11 && lo_state == 2'b00));

   // R8
   dn_into_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && !up && count == COUNT_W'(3)) |=> (hi_state == 2'b11 && lo_state == 2'b10));

   // R9
   dn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && !up && count == '0) |=> (lo_state == 2'b11 && hi_state == 2'b10));

   // R10
   decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_state == 2'b11) ? (count == COUNT_W'(lo_state))
                          : (count == COUNT_W'(3) + COUNT_W'(hi_state)));
endmodule

bind split_updown_counter split_counter_chk #(.COUNT_W(COUNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .up(up), .dn(dn),
   .count(count), .lo_state(lo_state), .hi_state(hi_state)
);

// File: tb/sim_split_updown_counter.sv
module sim_split_updown_counter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up = 1'b0;
   logic dn = 1'b0;
   logic [2:0] count;
   logic [1:0] lo_state, hi_state;

   int n_run = 0;
   int n_fail = 0;
   int model = 0;

   always #5 clk = ~clk;

   split_updown_counter #(.COUNT_W(3)) u0 (
      .clk(clk), .rst_n(rst_n), .up(up), .dn(dn),
      .count(count), .lo_state(lo_state), .hi_state(hi_state)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Compare all outputs against the position model (R10, R5)
   task automatic check_all(input string req);
      int lo_e, hi_e;
      lo_e = (model < 3) ? model : 3;
      hi_e = (model >= 3) ? model - 3 : 3;
      check({req, " count"}, int'(count), model);
      check({req, " lo_state (R10 R5)"}, int'(lo_state), lo_e);
      check({req, " hi_state (R10 R5)"}, int'(hi_state), hi_e);
   endtask

   task automatic step(input logic u, input logic d);
      @(negedge clk);
      up = u; dn = d;
      @(posedge clk);
      #1;
      if (u && !d)      model = (model + 1) % 6;
      else if (d && !u) model = (model + 5) % 6;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      up = 1'b0; dn = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      model = 0;
      check_all("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0);
      check_all("R1 after release");
   endtask

   task automatic t_up_sweep;
      for (int i = 0; i < 13; i++) begin
         step(1'b1, 1'b0);
         check_all("R2 up sweep");
      end
   endtask

   task automatic t_dn_sweep;
      for (int i = 0; i < 13; i++) begin
         step(1'b0, 1'b1);
         check_all("R3 down sweep");
      end
   endtask

   task automatic t_hold;
      for (int k = 0; k < 6; k++) begin
         step(1'b0, 1'b0);
         check_all("R4 idle hold");
         step(1'b1, 1'b1);
         check_all("R4 both-high hold");
         step(1'b1, 1'b0);
      end
   endtask

   task automatic go_to(input int target);
      for (int i = 0; i < 6 && model != target; i++) step(1'b1, 1'b0);
   endtask

   task automatic t_boundaries;
      go_to(2);
      step(1'b1, 1'b0);
      check("R6 lo parks", int'(lo_state), 3);
      check("R6 hi enters first", int'(hi_state), 0);
      go_to(5);
      step(1'b1, 1'b0);
      check("R7 hi parks", int'(hi_state), 3);
      check("R7 lo enters first", int'(lo_state), 0);
      go_to(3);
      step(1'b0, 1'b1);
      check("R8 hi parks", int'(hi_state), 3);
      check("R8 lo enters last", int'(lo_state), 2);
      go_to(0);
      step(1'b0, 1'b1);
      check("R9 lo parks", int'(lo_state), 3);
      check("R9 hi enters last", int'(hi_state), 2);
      check("R9 count wraps to 5", int'(count), 5);
   endtask

   task automatic t_mixed;
      logic [1:0] pat [10] = '{2'b10, 2'b10, 2'b01, 2'b10, 2'b10, 2'b10, 2'b11, 2'b01, 2'b01, 2'b00};
      foreach (pat[j]) begin
         step(pat[j][1], pat[j][0]);
         check_all("R2 R3 R4 mixed pattern");
      end
   endtask

   initial begin
      t_reset();
      t_up_sweep();
      t_dn_sweep();
      t_hold();
      t_boundaries();
      t_mixed();
      t_reset();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule